// File: doc/BRIEF.md
# Addressed Serial Display Data Loader

This block takes display data from a three-wire serial link (a frame enable, a shift clock and a data line) and turns it into the latched on/off pattern for a multiplexed segment display. Each segment has up to three common phases. While the frame enable is high, every rising shift-clock edge pushes one data bit into a 72-stage static shift register. When the frame enable falls, the register contents are committed to a 186-bit display latch.

The last three bits of a frame form a select field. Each select bit names one of three segment groups, and every group whose bit is set takes the payload. A frame can refresh one group, several groups or none. All bit positions are counted back from the end of the frame, so a host can leave out the data for unused leading segments and send a shorter frame.

A mode pin chooses the two-phase layout (48-bit full frame) or the three-phase layout (72-bit full frame). The serial pins are sampled in the `clk` domain and must be synchronous to it, each level held for at least one `clk` cycle. The link has no back-pressure: every qualified clock edge is taken and nothing stalls the sender. The control and mode pins are plain levels.

Top module: `serial_seg_loader`

## Requirements
- R1: While `rst_n` is low, and after reset until the first commit, `disp_pattern` is all zero.
- R2: A data bit is taken only on a rising edge of `ser_clk` while `ser_ce` is high. Shift-clock edges while `ser_ce` is low leave the register unchanged, and a later commit shows the earlier contents.
- R3: The latch changes only in the cycle after `ser_ce` falls. A rising `ser_ce`, and the shifting itself, leave `disp_pattern` unchanged.
- R4: Call the last bit shifted B(0), the one before it B(1), and so on. B(2) selects group 0 (segments 0-20), B(1) selects group 1 (segments 21-41) and B(0) selects group 2 (segments 42-61). Any combination of set bits updates all the selected groups from the same payload.
- R5: A group whose select bit is 0 keeps its previous contents when the latch is committed.
- R6: With `two_phase`=1, segment s within its group, phase p (0 or 1) is taken from B(47-(2s+p)). Phase 2 of every selected segment is written 0. `disp_pattern` bit index is seg*3+phase.
- R7: With `two_phase`=0, segment s within its group, phase p (0..2) is taken from B(71-(3s+p)).
- R8: A frame shorter than the full length updates the selected groups by the same end-relative positions. Segments whose bits were not sent take whatever older bits are still at those positions.
- R9: Group 2 has only 20 segments. Bits that would belong to a 21st segment in that group are ignored.
- R10: Shifted bits are held for any length of time with `ser_clk` stopped, and a late commit still delivers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_ce | input | 1 | Frame enable; high qualifies shifting, falling edge commits |
| ser_data | input | 1 | Serial data, first bit of the frame first |
| two_phase | input | 1 | 1 = two-phase layout, 0 = three-phase layout, sampled at commit |
| disp_pattern | output | 186 | Latched pattern, bit seg*3+phase |

## Verification
The bench builds the block with its default parameters: 62 segments in groups of 21, 3 padding bits in two-phase frames and 6 in three-phase frames. These defaults make the last group short, so the ignored 21st-segment slot is reached. The bench mixes full and shortened frames in both layouts with every select pattern, including all-zero and all-one. It holds data in the register for thousands of cycles before committing, and it runs shift-clock activity with the enable low.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  // Position, counted back from the last bit shifted in, of one display bit
  function automatic int slot_index(input int seg_in_grp, input int phase,
                                    input int phases, input int group_segs,
                                    input int pad_bits, input int sel_bits);
    return sel_bits + pad_bits + group_segs * phases - 1 - (seg_in_grp * phases + phase);
  endfunction
endpackage

// File: rtl/sdl_shift_front.sv
module sdl_shift_front #(
  parameter int SHIFT_LEN = 72
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_ce,
  input  logic                 ser_data,
  output logic [SHIFT_LEN-1:0] shift_q,
  output logic                 commit_p
);
  logic sck_q;
  logic ce_q;
  logic shift_en;

  assign shift_en = ser_clk & ~sck_q & ser_ce;
  assign commit_p = ~ser_ce & ce_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ce_q    <= 1'b0;
      shift_q <= '0;
    end else begin
      sck_q <= ser_clk;
      ce_q  <= ser_ce;
      if (shift_en) shift_q <= {shift_q[SHIFT_LEN-2:0], ser_data};
    end
  end

  // R2: no shifting while the frame enable is low
  assert_no_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_ce |=> $stable(shift_q));

  // R2, R10: a qualified clock edge moves the register by exactly one place
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ce && ser_clk && !sck_q) |=>
      (shift_q[0] == $past(ser_data)) &&
      (shift_q[SHIFT_LEN-1:1] == $past(shift_q[SHIFT_LEN-2:0])));

  // R10: with the shift clock still high, contents hold
  assert_static_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && ser_clk) |=> $stable(shift_q));
endmodule

// File: rtl/sdl_group_latch.sv
module sdl_group_latch
  import sdl_pkg::*;
#(
  parameter int GROUP_IDX   = 0,
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_SEGS  = 21,
  parameter int SEGS_HERE   = 21,
  parameter int HALF_PAD    = 3,
  parameter int THIRD_PAD   = 6,
  parameter int SHIFT_LEN   = 72,
  parameter int MAX_PHASES  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit_p,
  input  logic                            two_phase,
  input  logic [SHIFT_LEN-1:0]            shift_q,
  output logic [SEGS_HERE*MAX_PHASES-1:0] grp_bits
);
  localparam int WIDTH   = SEGS_HERE * MAX_PHASES;
  localparam int SEL_POS = NUM_GROUPS - 1 - GROUP_IDX;

  logic             sel;
  logic [WIDTH-1:0] half_v;
  logic [WIDTH-1:0] third_v;
  logic [SEGS_HERE-1:0] top_phase;

  assign sel = shift_q[SEL_POS];

  for (genvar s = 0; s < SEGS_HERE; s++) begin : g_seg
    for (genvar p = 0; p < MAX_PHASES; p++) begin : g_ph
      localparam int IH = slot_index(s, p, 2, GROUP_SEGS, HALF_PAD, NUM_GROUPS);
      localparam int IT = slot_index(s, p, 3, GROUP_SEGS, THIRD_PAD, NUM_GROUPS);
      if (p < 2) begin : g_used
        assign half_v[s*MAX_PHASES+p] = shift_q[IH];
      end else begin : g_blank
        assign half_v[s*MAX_PHASES+p] = 1'b0;
      end
      assign third_v[s*MAX_PHASES+p] = shift_q[IT];
    end
    assign top_phase[s] = grp_bits[s*MAX_PHASES+2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              grp_bits <= '0;
    else if (commit_p && sel) grp_bits <= two_phase ? half_v : third_v;
  end

  // R3: no commit, no change
  assert_hold_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_p |=> $stable(grp_bits));

  // R5: unselected group keeps its contents
  assert_unselected_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_p && !shift_q[SEL_POS]) |=> $stable(grp_bits));

  // R6: two-phase commit blanks the third phase
  assert_third_phase_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_p && sel && two_phase) |=> (top_phase == '0));
endmodule

// File: rtl/serial_seg_loader.sv
module serial_seg_loader #(
  parameter int SEG_COUNT  = 62,
  parameter int GROUP_SEGS = 21,
  parameter int HALF_PAD   = 3,
  parameter int THIRD_PAD  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_ce,
  input  logic                 ser_data,
  input  logic                 two_phase,
  output logic [SEG_COUNT*3-1:0] disp_pattern
);
  localparam int MAX_PHASES = 3;
  localparam int NUM_GROUPS = (SEG_COUNT + GROUP_SEGS - 1) / GROUP_SEGS;
  localparam int SHIFT_LEN  = GROUP_SEGS * MAX_PHASES + THIRD_PAD + NUM_GROUPS;

  logic [SHIFT_LEN-1:0] shift_q;
  logic                 commit_p;

  sdl_shift_front #(.SHIFT_LEN(SHIFT_LEN)) front_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_ce   (ser_ce),
    .ser_data (ser_data),
    .shift_q  (shift_q),
    .commit_p (commit_p)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int FIRST = g * GROUP_SEGS;
    localparam int SEGS_HERE = (SEG_COUNT - FIRST < GROUP_SEGS) ? SEG_COUNT - FIRST : GROUP_SEGS;
    sdl_group_latch #(
      .GROUP_IDX  (g),
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_SEGS (GROUP_SEGS),
      .SEGS_HERE  (SEGS_HERE),
      .HALF_PAD   (HALF_PAD),
      .THIRD_PAD  (THIRD_PAD),
      .SHIFT_LEN  (SHIFT_LEN),
      .MAX_PHASES (MAX_PHASES)
    ) latch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_p  (commit_p),
      .two_phase (two_phase),
      .shift_q   (shift_q),
      .grp_bits  (disp_pattern[FIRST*MAX_PHASES +: SEGS_HERE*MAX_PHASES])
    );
  end

  // R4, R5: an empty select field leaves the whole pattern alone
  assert_empty_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_p && shift_q[NUM_GROUPS-1:0] == '0) |=> $stable(disp_pattern));

  // R3: a rising frame enable alone never moves the pattern
  assert_rise_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_ce) |=> $stable(disp_pattern));
endmodule

// File: tb/serial_seg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_seg_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_ce = 1'b0;
  logic ser_data = 1'b0;
  logic two_phase = 1'b0;
  logic [185:0] disp_pattern;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [71:0]  m_sr  = '0;
  logic [185:0] m_pat = '0;

  always #2 clk = ~clk;

  serial_seg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ce(ser_ce),
    .ser_data(ser_data), .two_phase(two_phase), .disp_pattern(disp_pattern)
  );

  // Expected pattern after a commit, computed from the end-relative rules
  function automatic logic [185:0] apply(input logic [185:0] old, input logic [71:0] sr,
                                         input logic two);
    logic [185:0] r = old;
    for (int seg = 0; seg < 62; seg++) begin
      int g = seg / 21;
      int s = seg % 21;
      if (sr[2-g]) begin
        for (int p = 0; p < 3; p++) begin
          if (two) r[seg*3+p] = (p < 2) ? sr[47-(2*s+p)] : 1'b0;
          else     r[seg*3+p] = sr[71-(3*s+p)];
        end
      end
    end
    return r;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [185:0] exp);
    checks++;
    if (disp_pattern !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, disp_pattern, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    ser_clk  = 1'b0;
    wait_n(2);
    ser_clk = 1'b1;
    if (ser_ce) m_sr = {m_sr[70:0], b};
    wait_n(2);
    ser_clk = 1'b0;
  endtask

  task automatic commit(input string req);
    ser_ce = 1'b0;
    m_pat = apply(m_pat, m_sr, two_phase);
    wait_n(3);
    check(req, m_pat);
  endtask

  // addr[2] selects group 0, addr[0] selects group 2
  task automatic frame(input logic two, input int len, input logic [2:0] addr,
                       input string req);
    logic [71:0] f = {$urandom, $urandom, $urandom};
    f[len-3] = addr[2];
    f[len-2] = addr[1];
    f[len-1] = addr[0];
    two_phase = two;
    ser_ce = 1'b1;
    wait_n(2);
    for (int k = 0; k < len; k++) send_bit(f[k]);
    wait_n(1);
    check("R3 before fall", m_pat);
    commit(req);
  endtask

  initial begin
    wait_n(150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    wait_n(5);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 after reset", '0);

    frame(1'b1, 48, 3'b100, "R6 R4 group0");
    frame(1'b1, 48, 3'b011, "R6 R4 groups1-2");
    frame(1'b0, 72, 3'b010, "R7 R5 group1");
    frame(1'b0, 72, 3'b001, "R7 R9 group2");
    frame(1'b0, 72, 3'b111, "R7 R4 all");
    frame(1'b0, 72, 3'b000, "R5 none");
    frame(1'b1, 44, 3'b100, "R8 short two-phase");
    frame(1'b0, 60, 3'b101, "R8 short three-phase");

    // R3: rising enable alone
    ser_ce = 1'b1;
    wait_n(4);
    check("R3 rise", m_pat);

    // R2: clock edges with enable low are ignored
    ser_ce = 1'b0;
    wait_n(2);
    check("R3 empty commit", apply(m_pat, m_sr, two_phase));
    m_pat = apply(m_pat, m_sr, two_phase);
    for (int i = 0; i < 12; i++) send_bit(1'($urandom));
    ser_ce = 1'b1;
    wait_n(2);
    commit("R2 idle clocks");

    // R10: long pause with clock stopped
    two_phase = 1'b0;
    ser_ce = 1'b1;
    wait_n(2);
    for (int k = 0; k < 72; k++) send_bit((k >= 69) ? 1'b1 : 1'($urandom));
    wait_n(5000);
    check("R10 hold before fall", m_pat);
    commit("R10 late commit");

    for (int n = 0; n < 40; n++) begin
      logic two = 1'($urandom);
      int full = two ? 48 : 72;
      int len = full - int'($urandom % 8);
      frame(two, len, 3'($urandom), "R4 R6 R7 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule